// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs Clause 22 management transactions towards an Ethernet PHY. Software writes one 32-bit management word that holds the whole frame: start code, operation, PHY address, register address, turnaround code and 16 data bits. The block then sends 32 preamble ones followed by the 32 word bits, most significant bit first, on MDIO. The MDC clock is derived from the system clock by a divisor chosen with a 3-bit select input. For a read, the block lets go of MDIO at the turnaround and shifts in the 16 bits the PHY returns. When the frame ends, it writes those bits into the data field of the stored word.

Software polls the idle flag until it goes high and then reads the word back. A separate port-enable input gates MDC and the MDIO output enable. While it is low the MDC generator is frozen, so a pending or running frame waits and resumes when the port is enabled again.

The sequencer has three states. IDLE waits for a write. ARM is entered on an accepted write and waits for the next MDC falling edge. SHIFT is entered on that falling edge, which also drives the first preamble bit. SHIFT moves to the next bit on each falling edge and returns to IDLE on the falling edge after the 64th bit.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset, idle is 1, mdc is 0, mdio_oe is 0 and mgmt_word reads 0.
- R2: Word layout is start [31:30], operation [29:28] (2'b10 means read; any other value is treated as a write), PHY address [27:23], register address [22:18], turnaround [17:16] and data [15:0]. A transfer produces exactly 64 MDC rising edges: 32 with MDIO at 1, then word bits 31 down to 0.
- R3: The MDC period in system clocks is 8, 16, 32, 48, 64 and 96 for div_sel codes 0 to 5, and 96 for codes 6 and 7, with equal high and low times.
- R4: mdio_o changes only together with a falling edge of MDC, and the PHY's mdio_i is sampled on MDC rising edges.
- R5: A write while idle clears idle from the next cycle. Idle stays 0 until the MDC falling edge that follows the 64th rising edge.
- R6: On a read, mdio_oe is 0 from frame bit 46 (the first turnaround bit, counting the preamble from 0) to the end of the frame. Before that it is 1.
- R7: After a read, mgmt_word[15:0] holds the bits sampled at rising edges 48 to 63, first sample in bit 15, and bits [31:16] are unchanged. After a write, mgmt_word still holds the value written.
- R8: A write to mgmt_word while a transfer is in progress is ignored. Neither the bits sent nor the stored word change.
- R9: While port_en is 0, mdc and mdio_oe are 0 and the transfer does not advance. A word written in that state is accepted, and its frame is sent once port_en returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Management port enable |
| div_sel | input | 3 | MDC divisor select code |
| wr_en | input | 1 | Write strobe for the management word |
| wr_data | input | 32 | Management word to write |
| mgmt_word | output | 32 | Stored management word (read port) |
| idle | output | 1 | High when no transfer is pending or running |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input data |

## Verification
A bit counter that slips by one shifts the whole frame. The next rising edges then capture a wrong preamble length or address bit, and the total edge count is no longer 64, so the error shows during the same transfer. A turnaround compare that is off moves the output-enable release, which shows at rising edge 45 or 46. A missed or extra sample shifts the read data, which shows in mgmt_word as soon as idle rises. A wrong divider entry shows in the first MDC period measured for that code. A busy guard that leaks corrupts the frame within the next few MDC cycles and also changes the readback.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    localparam int WORD_W    = 32;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int TOT_LEN   = PRE_LEN + WORD_W;
    localparam int CNT_W     = $clog2(TOT_LEN);
    localparam int TA_POS    = PRE_LEN + 14;
    localparam int DATA_POS  = PRE_LEN + 16;
    localparam int OP_HI     = 29;
    localparam int SEL_W     = 3;
    localparam int HALF_W    = 6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_SHIFT = 2'd2
    } seq_state_t;

    function automatic logic [HALF_W-1:0] half_period(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    half_period = HALF_W'(4);
            3'd1:    half_period = HALF_W'(8);
            3'd2:    half_period = HALF_W'(16);
            3'd3:    half_period = HALF_W'(24);
            3'd4:    half_period = HALF_W'(32);
            default: half_period = HALF_W'(48);
        endcase
    endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             mdc_raw,
    output logic             rise,
    output logic             fall
);
    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] half;
    logic              wrap;

    assign half = half_period(sel);
    assign wrap = run && (cnt_q >= half - 1'b1);
    assign rise = wrap && !mdc_raw;
    assign fall = wrap && mdc_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            mdc_raw <= 1'b0;
        end else if (run) begin
            if (wrap) begin
                cnt_q   <= '0;
                mdc_raw <= !mdc_raw;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R9
    mdc_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(mdc_raw) && $stable(cnt_q));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [WORD_W-1:0] word_in,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              op_rd,
    output logic [DATA_W-1:0] rdata,
    output logic              mdio_o,
    output logic              mdio_oe
);
    seq_state_t        state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nxt;
    logic              last_bit;

    assign busy     = (state_q != ST_IDLE);
    assign op_rd    = (word_q[OP_HI:OP_HI-1] == 2'b10);
    assign cnt_nxt  = cnt_q + 1'b1;
    assign last_bit = (cnt_q == CNT_W'(TOT_LEN - 1));
    assign done     = (state_q == ST_SHIFT) && fall && last_bit;

    function automatic logic frame_bit(input logic [CNT_W-1:0] idx,
                                       input logic [WORD_W-1:0] w);
        if (int'(idx) < PRE_LEN)
            frame_bit = 1'b1;
        else
            frame_bit = w[TOT_LEN - 1 - int'(idx)];
    endfunction

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req)              state_d = ST_ARM;
            ST_ARM:   if (fall)             state_d = ST_SHIFT;
            ST_SHIFT: if (fall && last_bit) state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            cnt_q   <= '0;
            rdata   <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        word_q <= word_in;
                        cnt_q  <= '0;
                    end
                end
                ST_ARM: begin
                    if (fall) begin
                        mdio_o  <= frame_bit('0, word_q);
                        mdio_oe <= 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (rise && op_rd && int'(cnt_q) >= DATA_POS)
                        rdata <= {rdata[DATA_W-2:0], mdio_i};
                    if (fall) begin
                        if (last_bit) begin
                            mdio_oe <= 1'b0;
                        end else begin
                            cnt_q   <= cnt_nxt;
                            mdio_o  <= frame_bit(cnt_nxt, word_q);
                            mdio_oe <= !(op_rd && int'(cnt_nxt) >= TA_POS);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R6
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && op_rd && int'(cnt_q) >= TA_POS) |-> !mdio_oe);
    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> $stable(word_q));
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] mgmt_word,
    output logic              idle,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic              mdc_raw, rise, fall;
    logic              busy, done, op_rd, oe_raw;
    logic [DATA_W-1:0] rdata;

    mdio_mdc_gen u_mdc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (port_en),
        .sel     (div_sel),
        .mdc_raw (mdc_raw),
        .rise    (rise),
        .fall    (fall)
    );

    mdio_frame_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (wr_en),
        .word_in (wr_data),
        .rise    (rise),
        .fall    (fall),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .done    (done),
        .op_rd   (op_rd),
        .rdata   (rdata),
        .mdio_o  (mdio_o),
        .mdio_oe (oe_raw)
    );

    assign idle    = !busy;
    assign mdc     = mdc_raw && port_en;
    assign mdio_oe = oe_raw && port_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mgmt_word <= '0;
        else if (wr_en && !busy)
            mgmt_word <= wr_data;
        else if (done && op_rd)
            mgmt_word[DATA_W-1:0] <= rdata;
    end

    // R4
    out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $fell(mdc_raw));
    // R5
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idle) |=> !idle);
    // R8
    busy_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !idle && !done) |=> $stable(mgmt_word));
endmodule

// File: tb/test_mdio_frame_ctrl.sv
module test_mdio_frame_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b1;
    logic [2:0]  div_sel = 3'd0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] mgmt_word;
    logic        idle, mdc, mdio_o, mdio_oe;
    logic        mdio_i;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic        mon_on = 1'b0;
    logic        started = 1'b0;
    logic        prev_mdc = 1'b0;
    logic        prev_o = 1'b1;
    int          k = 0;
    int          edge_viol = 0;
    int          last_rise = 0;
    int          period = 0;
    logic [15:0] phy_data = '0;
    logic [63:0] cap_o;
    logic [63:0] cap_oe;

    mdio_frame_ctrl i_mdio_frame_ctrl (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .div_sel(div_sel),
        .wr_en(wr_en), .wr_data(wr_data), .mgmt_word(mgmt_word), .idle(idle),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // PHY model and line monitor
    always @(negedge clk) begin
        if (!mon_on) begin
            mdio_i = 1'b0;
        end else begin
            if (mdio_o !== prev_o && !(prev_mdc && !mdc)) edge_viol++;
            if (!prev_mdc && mdc) begin
                period = cyc - last_rise;
                last_rise = cyc;
                if (started) begin
                    if (k < 64) begin
                        cap_o[k]  = mdio_o;
                        cap_oe[k] = mdio_oe;
                    end
                    k++;
                    mdio_i = (k >= 48 && k < 64) ? phy_data[63 - k] : 1'b0;
                end
            end
            if (prev_mdc && !mdc) started = 1'b1;
        end
        prev_mdc = mdc;
        prev_o   = mdio_o;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_period(input int sel);
        if (sel <= 2) return 8 << sel;
        if (sel == 3) return 48;
        if (sel == 4) return 64;
        return 96;
    endfunction

    task automatic xfer(input logic [31:0] w, input logic [15:0] pd, input int sel,
                        input bit mid_wr, input bit paused);
        logic [63:0] exp_frame;
        logic [31:0] exp_word;
        bit          rd;
        int          bad_o, bad_oe, n;
        rd        = (w[29:28] == 2'b10);
        exp_frame = {32'hFFFF_FFFF, w};
        exp_word  = rd ? {w[31:16], pd} : w;
        @(negedge clk);
        div_sel = 3'(sel); phy_data = pd; k = 0; started = 1'b0; edge_viol = 0;
        mon_on = 1'b1;
        if (paused) port_en = 1'b0;
        wr_data = w; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check(idle == 1'b0, "R5 idle low after write", idle, 0);
        if (paused) begin
            n = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (mdc || mdio_oe || idle) n++;
            end
            check(n == 0, "R9 paused port quiet", n, 0);
            check(k == 0, "R9 no edges while paused", k, 0);
            port_en = 1'b1;
        end
        if (mid_wr) begin
            repeat (150) @(negedge clk);
            wr_data = ~w; wr_en = 1'b1;
            @(negedge clk);
            wr_en = 1'b0;
        end
        n = 0;
        while (!idle && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(idle == 1'b1, "R5 transfer completes", idle, 1);
        check(k == 64, "R2 rising edge count", k, 64);
        bad_o = 0; bad_oe = 0;
        for (int i = 0; i < 64; i++) begin
            if (!(rd && i >= 46) && cap_o[i] !== exp_frame[63 - i]) bad_o++;
            if (cap_oe[i] !== ((rd && i >= 46) ? 1'b0 : 1'b1)) bad_oe++;
        end
        check(bad_o == 0, mid_wr ? "R8 frame bits unaffected" : "R2 frame bits", bad_o, 0);
        check(bad_oe == 0, "R6 output enable pattern", bad_oe, 0);
        check(edge_viol == 0, "R4 output changes on MDC fall", edge_viol, 0);
        check(period == exp_period(sel), "R3 MDC period", period, exp_period(sel));
        check(mgmt_word == exp_word, mid_wr ? "R8 word unchanged" : "R7 readback", mgmt_word, exp_word);
        mon_on = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(idle == 1'b1, "R1 idle", idle, 1);
        check(mdc == 1'b0, "R1 mdc", mdc, 0);
        check(mdio_oe == 1'b0, "R1 oe", mdio_oe, 0);
        check(mgmt_word == 32'h0, "R1 word", mgmt_word, 0);
        rst_n = 1'b1;
        for (int s = 0; s < 8; s++) begin
            logic [4:0]  phy;
            logic [4:0]  rg;
            logic [15:0] d;
            phy = 5'(3 * s + 1);
            rg  = 5'(31 - 2 * s);
            d   = 16'(16'hA5C3 ^ (s * 16'h1357));
            xfer({2'b01, 2'b01, phy, rg, 2'b10, d}, 16'h0, s, 1'b0, 1'b0);
            xfer({2'b01, 2'b10, phy, rg, 2'b10, 16'h0}, ~d, s, 1'b0, 1'b0);
        end
        xfer({2'b01, 2'b01, 5'd9, 5'd4, 2'b10, 16'h8001}, 16'h0, 1, 1'b1, 1'b0);
        xfer({2'b01, 2'b10, 5'd17, 5'd2, 2'b10, 16'h0}, 16'h3C5A, 0, 1'b1, 1'b0);
        xfer({2'b01, 2'b10, 5'd31, 5'd31, 2'b10, 16'h0}, 16'hFFFE, 0, 1'b0, 1'b1);
        xfer({2'b01, 2'b01, 5'd0, 5'd0, 2'b10, 16'h0001}, 16'h0, 2, 1'b0, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc >= 190000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule